// File: doc/BRIEF.md
# Serial Register-File Slave for a Timekeeping Device

This block is the serial front end of a small real-time-clock device. An SPI master opens a transaction by raising the active-high chip select. It then sends one command byte, followed by any number of data bytes. The command byte carries a direction flag and a 7-bit start address. Each later data byte is either written to, or read from, the register space at an address that advances by one per byte. The pointer wraps from 0x7F back to 0x00.

The register space is mostly held by the timekeeping and alarm logic next to this block. That space covers seconds through year at 0x00–0x06, two four-byte alarm banks at 0x07–0x0A and 0x0B–0x0E, status at 0x10, the charger setting at 0x11, and 96 bytes of scratch RAM at 0x20–0x7F. The block reaches that logic through a read strobe, a write strobe, an address, write data and a combinational read-data return.

The control byte at 0x0F is held inside the block. Its bit 6 is the write-protect flag, so the block can gate writes locally. The SPI inputs are oversampled by the fast system clock through synchronisers. Serial clock edges are then detected in the system clock domain.

Top module: `rtc_spi_regif`

## Requirements
- R1: Bytes are 8 bits, shifted MSB first. The first byte after chip select rises is the command: bit 7 = 1 selects write, bit 7 = 0 selects read, and bits 6:0 give the start address.
- R2: The serial clock idles low and uses CPHA=1. MOSI is sampled on the falling edge. MISO changes after the rising edge, and is held at 0 while chip select is low.
- R3: Each data byte uses the next address in sequence. The pointer wraps from 0x7F to 0x00 within a burst.
- R4: The read data for a byte is fetched when the last bit of the command byte, or of the previous data byte, is sampled. The fetch pulses reg_rd_o for one cycle with reg_addr_o, except at 0x0F and at 0x12–0x1F.
- R5: While control bit 6 (write protect) is 1, writes to every address other than 0x0F produce no write strobe. A write to 0x0F is always taken. The new protect state applies from the next byte of the same burst.
- R6: Control bits 5:3 always read as 0 and are 0 on ctrl_o. Status (0x10) bits 7:2 always read as 0.
- R7: Addresses 0x12–0x1F read as 0x00, and writes to them produce no strobe.
- R8: Dropping chip select returns the block to the command phase and discards any incomplete byte. A byte whose 8th falling edge coincides with chip select dropping is also discarded.
- R9: After reset, ctrl_o equals CTRL_RESET with bits 5:3 cleared (by default 0x40, protect set), MISO is 0 and no strobe is active.
- R10: Every accepted data byte of a write gives exactly one cycle of reg_wr_o, carrying that byte's address on reg_addr_o and the raw byte on reg_wdata_o. The read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| cs_i | input | 1 | Chip select, active high |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 7 | Register address for the active strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Combinational read data for reg_addr_o |
| ctrl_o | output | 8 | Current control byte |

## Verification
Two events can land in the same system-clock cycle. The first is the synchronised falling edge that completes a byte. The second is chip select being seen low.

The bench provokes this by lowering chip select together with the 8th falling edge of a write data byte. It then reads the target address back and expects the old value. It also counts write strobes and expects none from that byte.

A second case arises within a single burst. A control write that sets the protect bit must take effect on the byte directly after it. The bench judges this by writing 0x0F and 0x10 in one burst and expecting 0x10 to remain unchanged.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h10;
  localparam logic [ADDR_W-1:0] HOLE_LO   = 7'h12;
  localparam logic [ADDR_W-1:0] HOLE_HI   = 7'h1F;
  localparam int WP_BIT = 6;
  localparam logic [DATA_W-1:0] CTRL_MASK = 8'hC7;
  localparam logic [DATA_W-1:0] STAT_MASK = 8'h03;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  function automatic logic is_hole(input logic [ADDR_W-1:0] a);
    return (a >= HOLE_LO) && (a <= HOLE_HI);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2,
  parameter int N      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= {q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = q[STAGES-1];
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import rtc_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sclk_s_i,
  input  logic              mosi_s_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              miso_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sclk_q, rise, fall, done_q, miso_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_sr_q, tx_sr_q;

  assign rise = sclk_s_i & ~sclk_q;
  assign fall = ~sclk_s_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
      miso_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      done_q <= 1'b0;
      if (!cs_s_i) begin
        // deselect has priority over any edge seen in the same cycle
        bit_cnt_q <= '0;
        tx_sr_q   <= '0;
        miso_q    <= 1'b0;
      end else begin
        if (fall) begin
          rx_sr_q   <= {rx_sr_q[DATA_W-2:0], mosi_s_i};
          bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST) done_q <= 1'b1;
        end
        if (rise) begin
          miso_q  <= tx_sr_q[DATA_W-1];
          tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
        end
        if (load_i) tx_sr_q <= load_data_i;
      end
    end
  end

  assign byte_done_o = done_q;
  assign rx_byte_o   = rx_sr_q;
  assign miso_o      = miso_q;

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> (bit_cnt_q == '0) && !miso_o);
  assert_byte_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> bit_cnt_q == '0);
endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
  import rtc_spi_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTRL_RESET = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [DATA_W-1:0] ctrl_o
);
  phase_e            phase_q;
  logic              is_wr_q;
  logic [ADDR_W-1:0] addr_q, rd_addr;
  logic [DATA_W-1:0] ctrl_q;
  logic              commit, cmd_done, data_done, rd_go, wr_go;

  assign commit    = byte_done_i & cs_s_i;
  assign cmd_done  = commit && (phase_q == PH_CMD);
  assign data_done = commit && (phase_q == PH_DATA);
  assign rd_addr   = cmd_done ? rx_byte_i[ADDR_W-1:0] : addr_q + 1'b1;
  assign rd_go     = (cmd_done && !rx_byte_i[DATA_W-1]) || (data_done && !is_wr_q);
  assign wr_go     = data_done && is_wr_q && !is_hole(addr_q) &&
                     (!ctrl_q[WP_BIT] || (addr_q == CTRL_ADDR));

  always_comb begin
    if (is_hole(rd_addr))            load_data_o = '0;
    else if (rd_addr == CTRL_ADDR)   load_data_o = ctrl_q;
    else if (rd_addr == STAT_ADDR)   load_data_o = reg_rdata_i & STAT_MASK;
    else                             load_data_o = reg_rdata_i;
  end

  assign load_o      = rd_go;
  assign reg_wr_o    = wr_go;
  assign reg_rd_o    = rd_go && !is_hole(rd_addr) && (rd_addr != CTRL_ADDR);
  assign reg_addr_o  = wr_go ? addr_q : rd_addr;
  assign reg_wdata_o = rx_byte_i;
  assign ctrl_o      = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      ctrl_q  <= CTRL_RESET & CTRL_MASK;
    end else begin
      if (!cs_s_i) begin
        phase_q <= PH_CMD;
      end else if (cmd_done) begin
        phase_q <= PH_DATA;
        is_wr_q <= rx_byte_i[DATA_W-1];
        addr_q  <= rx_byte_i[ADDR_W-1:0];
      end else if (data_done) begin
        addr_q  <= addr_q + 1'b1;
      end
      if (wr_go && (addr_q == CTRL_ADDR)) ctrl_q <= rx_byte_i & CTRL_MASK;
    end
  end

  assert_wp_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && ctrl_o[WP_BIT]) |-> reg_addr_o == CTRL_ADDR);
  assert_hole_no_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !is_hole(reg_addr_o));
  assert_ctrl_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_addr_o == CTRL_ADDR) |=> $stable(ctrl_o));
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_done |=> addr_q == $past(addr_q) + 1'b1);
  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_wr_o, reg_rd_o}));
endmodule

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif
  import rtc_spi_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CTRL_RESET  = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [2:0]        sync_v;
  logic              byte_done, load;
  logic [DATA_W-1:0] rx_byte, load_data;

  spi_in_sync #(.STAGES(SYNC_STAGES), .N(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({cs_i, sclk_i, mosi_i}),
    .sync_o  (sync_v)
  );

  spi_byte_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (sync_v[2]),
    .sclk_s_i    (sync_v[1]),
    .mosi_s_i    (sync_v[0]),
    .load_i      (load),
    .load_data_i (load_data),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .miso_o      (miso_o)
  );

  spi_reg_access #(.CTRL_RESET(CTRL_RESET)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (sync_v[2]),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .reg_rdata_i (reg_rdata_i),
    .load_o      (load),
    .load_data_o (load_data),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .ctrl_o      (ctrl_o)
  );
endmodule

// File: tb/sim_rtc_spi_regif.sv
module sim_rtc_spi_regif;
  localparam int HP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic miso, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, ctrl;

  logic [7:0] dev_mem [128];
  logic [7:0] exp_mem [128];
  logic [7:0] exp_ctrl;
  logic [7:0] wbuf [8];
  int n_chk = 0, n_err = 0, wr_cnt = 0, rd_cnt = 0;
  bit done_f = 0;

  always #4 clk = ~clk;

  rtc_spi_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .mosi_i(mosi),
    .miso_o(miso), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .ctrl_o(ctrl)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign reg_rdata = dev_mem[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) dev_mem[i] <= pat(i);
    end else if (reg_wr) begin
      dev_mem[reg_addr] <= reg_wdata;
    end
    if (rst_n && reg_wr) wr_cnt <= wr_cnt + 1;
    if (rst_n && reg_rd) rd_cnt <= rd_cnt + 1;
  end

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    if (a >= 7'h12 && a <= 7'h1F) return 8'h00;
    if (a == 7'h0F) return exp_ctrl;
    if (a == 7'h10) return exp_mem[a] & 8'h03;
    return exp_mem[a];
  endfunction

  task automatic model_wr(input logic [6:0] a, input logic [7:0] d);
    if (a >= 7'h12 && a <= 7'h1F) return;
    if (exp_ctrl[6] && a != 7'h0F) return;
    if (a == 7'h0F) exp_ctrl = d & 8'hC7;
    exp_mem[a] = d;
  endtask

  task automatic chk(input int act, input int expv, input string req, input string what);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input bit drop_last,
                      output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      sclk = 1'b1;
      wait_clk(HP);
      rx[7-i] = miso;
      sclk = 1'b0;
      if (drop_last && i == nbits - 1) cs = 1'b0;
      wait_clk(HP);
    end
  endtask

  task automatic cs_open();
    cs = 1'b1;
    wait_clk(HP);
  endtask

  task automatic cs_close();
    wait_clk(HP);
    cs = 1'b0;
    wait_clk(2 * HP);
  endtask

  task automatic spi_write(input logic [6:0] a, input int n);
    logic [7:0] r;
    cs_open();
    xfer({1'b1, a}, 8, 1'b0, r);
    for (int k = 0; k < n; k++) begin
      xfer(wbuf[k], 8, 1'b0, r);
      model_wr(7'(a + k), wbuf[k]);
    end
    cs_close();
  endtask

  task automatic spi_read(input logic [6:0] a, input int n, input string req);
    logic [7:0] r;
    cs_open();
    xfer({1'b0, a}, 8, 1'b0, r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, 1'b0, r);
      chk(r, exp_rd(7'(a + k)), req, $sformatf("read @%02h", 7'(a + k)));
    end
    cs_close();
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    int w0, r0;
    logic [7:0] r;
    seed_v = $urandom(32'h5EED);
    for (int i = 0; i < 128; i++) exp_mem[i] = pat(i);
    exp_ctrl = 8'h40;
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(4);

    // R9 reset state
    chk(ctrl, 8'h40, "R9", "ctrl after reset");
    chk(miso, 0, "R9", "miso after reset");
    chk(reg_wr | reg_rd, 0, "R9", "strobes after reset");

    // R4 R6: control burst, strobes only for 0x10 and 0x11
    r0 = rd_cnt;
    spi_read(7'h0F, 3, "R6");
    chk(rd_cnt - r0, 2, "R4", "read strobes for 0x0F burst");
    chk(miso, 0, "R2", "miso idle after deselect");

    // R5 protected write of the time bank
    for (int k = 0; k < 7; k++) wbuf[k] = 8'hA0 + 8'(k);
    w0 = wr_cnt;
    spi_write(7'h00, 7);
    chk(wr_cnt - w0, 0, "R5", "strobes under write protect");
    spi_read(7'h00, 7, "R1 R5");

    // R5 clear protect, R6 masked bits
    wbuf[0] = 8'hBF;
    spi_write(7'h0F, 1);
    chk(ctrl, 8'h87, "R6", "ctrl_o masked");
    spi_read(7'h0F, 1, "R6");
    wbuf[0] = 8'h00;
    spi_write(7'h0F, 1);
    chk(ctrl, 0, "R5", "protect cleared");

    // R1 R10 time bank write now accepted
    for (int k = 0; k < 7; k++) wbuf[k] = 8'h5A ^ 8'(k * 17);
    w0 = wr_cnt;
    spi_write(7'h00, 7);
    chk(wr_cnt - w0, 7, "R10", "one strobe per byte");
    spi_read(7'h00, 7, "R1 R10");

    // R5 protect set mid-burst blocks the next byte
    wbuf[0] = 8'h40; wbuf[1] = 8'hFE;
    spi_write(7'h0F, 2);
    spi_read(7'h0F, 2, "R5");
    wbuf[0] = 8'h00;
    spi_write(7'h0F, 1);

    // R7 hole writes dropped, reads zero
    for (int k = 0; k < 6; k++) wbuf[k] = 8'hC3 + 8'(k);
    w0 = wr_cnt;
    spi_write(7'h10, 6);
    chk(wr_cnt - w0, 2, "R7", "strobes across hole");
    spi_read(7'h10, 6, "R6 R7");

    // R3 wrap
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h11 * 8'(k + 3);
    spi_write(7'h7E, 4);
    spi_read(7'h7F, 3, "R3");

    // R8 abort mid-byte
    w0 = wr_cnt;
    cs_open();
    xfer(8'hA0, 8, 1'b0, r);
    xfer(8'h3C, 8, 1'b0, r);
    model_wr(7'h20, 8'h3C);
    xfer(8'hFF, 5, 1'b0, r);
    cs_close();
    chk(wr_cnt - w0, 1, "R8", "strobes with partial byte");
    spi_read(7'h20, 2, "R8");

    // R8 deselect coinciding with 8th falling edge
    w0 = wr_cnt;
    cs_open();
    xfer(8'hB0, 8, 1'b0, r);
    xfer(8'h96, 8, 1'b1, r);
    wait_clk(2 * HP);
    chk(wr_cnt - w0, 0, "R8", "strobe on coincident deselect");
    spi_read(7'h30, 1, "R8");

    // random transactions
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom_range(0, 127));
      n = $urandom_range(1, 6);
      if ($urandom_range(0, 1) == 1) begin
        for (int k = 0; k < n; k++) begin
          wbuf[k] = 8'($urandom);
          if (7'(a + k) == 7'h0F && $urandom_range(0, 3) != 0) wbuf[k][6] = 1'b0;
        end
        spi_write(a, n);
      end else begin
        spi_read(a, n, "R3 R4");
      end
    end

    // R10 external storage matches model at mapped, non-control addresses
    begin
      int bad = 0;
      for (int i = 0; i < 128; i++)
        if (!(i >= 8'h12 && i <= 8'h1F) && i != 8'h0F && dev_mem[i] !== exp_mem[i]) bad++;
      chk(bad, 0, "R10", "storage mismatches");
    end
    chk(ctrl, exp_ctrl, "R6", "final ctrl_o");
    finish_run();
  end
endmodule